// File: doc/BRIEF.md
# Secondary Clock Switch Controller

This block picks the system clock source from three candidates: a primary oscillator, an internal RC oscillator and a slow secondary oscillator, nominally 32.768 kHz with a period of about 30.52 µs. A 2-bit source-select value is written with a one-cycle strobe. When the secondary-oscillator enable input is low, a request for the secondary source is rewritten so that it points at a non-secondary source. Moves to the primary or RC source take effect on the next cycle. A move to the secondary source starts a pending switch. During that switch the four-phase core clock is frozen in its first phase and the primary oscillator is gated off. The switch completes after eight falling edges of the secondary clock have been seen.

All oscillators are treated as digital inputs. The controller runs on a fast free-running reference clock. Each oscillator passes through a two-flop synchronizer into that domain. The core phase advances on each synchronized rising edge of the active source, so the phase output is never driven from a raw oscillator edge. A write that changes the select value while a switch is pending cancels the switch. The new value is then judged against the source that is still active.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is asserted, sel_o is 00, active_src_o is 00 (primary), phase_o is 0001, switching_o is 0, sec_run_o is 0, ost_o is 0 and pri_clk_en_o is 1.
- R2: With the enable high, the select value is decoded from bit 0 first: if bit 0 is 1 (01 or 11) the secondary source is chosen; otherwise 10 chooses the RC source and 00 chooses the primary source. active_src_o reports 00 for primary, 01 for secondary and 10 for RC.
- R3: With the enable low, the stored select value is the requested value with bit 0 forced to 0. So 01 becomes 00, 11 becomes 10, and 00 and 10 are kept.
- R4: A write whose final value equals the stored value starts no switch and leaves active_src_o, switching_o and ost_o unchanged.
- R5: In the cycle after a write that starts a secondary switch, switching_o is 1, ost_o is 0 and pri_clk_en_o is 0.
- R6: While switching_o is 1, phase_o stays at 0001.
- R7: The switch does not complete before eight synchronized falling edges of the secondary clock have occurred after the write. It completes within six reference cycles of the eighth edge.
- R8: On completion switching_o falls, active_src_o becomes 01 and sec_run_o becomes 1.
- R9: A write that selects primary or RC, when that source differs from the active one, takes effect in the next cycle. active_src_o updates and sec_run_o clears. pri_clk_en_o is 1 only when primary is active and no switch is pending.
- R10: A value-changing write during a pending switch cancels it and clears the edge count. A later secondary request must then see eight fresh falling edges.
- R11: phase_o is always one-hot. It rotates 0001→0010→0100→1000→0001 on each synchronized rising edge of the active source.
- R12: A pulse on ost_set_i sets ost_o. A secondary-switch start in the same cycle takes precedence and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock for all control logic |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pri_osc_i | input | 1 | Primary oscillator, sampled as data |
| rc_osc_i | input | 1 | Internal RC oscillator, sampled as data |
| sec_osc_i | input | 1 | Secondary low-frequency oscillator, sampled as data |
| sel_wr_i | input | 1 | One-cycle write strobe for sel_i |
| sel_i | input | 2 | Requested source-select value |
| sec_osc_en_i | input | 1 | Secondary oscillator enable; low rewrites requests |
| ost_set_i | input | 1 | Sets the oscillator start-up status flag |
| sel_o | output | 2 | Stored select value after rewriting |
| active_src_o | output | 2 | Source now driving the core phases |
| phase_o | output | 4 | One-hot four-phase core clock |
| switching_o | output | 1 | Secondary switch pending |
| sec_run_o | output | 1 | Secondary source is the system clock |
| ost_o | output | 1 | Oscillator start-up status flag |
| pri_clk_en_o | output | 1 | Enable for the primary oscillator |

## Verification
The assertions assume every oscillator input is slow compared with the reference clock. Each high and low phase must span several reference cycles, so every edge survives the two-flop synchronizer and is detected exactly once. The bench keeps all oscillators at two or more reference cycles per half period. It issues secondary requests just after a rising secondary edge, so that no falling edge is already inside the synchronizer when the write lands. The bench also drives the strobe and data only on falling reference edges.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01,
    SRC_RC  = 2'b10
  } src_e;

  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned PH_W     = 4;
  localparam logic [PH_W-1:0] PH_FIRST = 4'b0001;

  function automatic src_e decode_sel(input logic [1:0] v);
    if (v[0])      return SRC_SEC;
    else if (v[1]) return SRC_RC;
    else           return SRC_PRI;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] shreg_q;
  logic [STAGES:0] shreg_d;
  logic            level;
  logic            prev;

  always_comb shreg_d = {shreg_q[STAGES-1:0], async_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else         shreg_q <= shreg_d;
  end

  assign level  = shreg_q[STAGES-1];
  assign prev   = shreg_q[STAGES];
  assign rise_o = level & ~prev;
  assign fall_o = ~level & prev;
endmodule

// File: rtl/clksw_sel.sv
module clksw_sel
  import clksw_pkg::*;
(
  input  logic [1:0] req_i,
  input  logic       osc_en_i,
  output logic [1:0] final_o,
  output src_e       tgt_o
);
  always_comb begin
    final_o = osc_en_i ? req_i : {req_i[1], 1'b0};
    tgt_o   = decode_sel(final_o);
  end
endmodule

// File: rtl/clksw_phase.sv
module clksw_phase
  import clksw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            tick_i,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (hold_i)      ph_d = PH_FIRST;
    else if (tick_i) ph_d = {ph_q[PH_W-2:0], ph_q[PH_W-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_FIRST;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned EDGE_COUNT  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pri_osc_i,
  input  logic       rc_osc_i,
  input  logic       sec_osc_i,
  input  logic       sel_wr_i,
  input  logic [1:0] sel_i,
  input  logic       sec_osc_en_i,
  input  logic       ost_set_i,
  output logic [1:0] sel_o,
  output logic [1:0] active_src_o,
  output logic [3:0] phase_o,
  output logic       switching_o,
  output logic       sec_run_o,
  output logic       ost_o,
  output logic       pri_clk_en_o
);
  localparam int unsigned CW = $clog2(EDGE_COUNT + 1);
  localparam logic [CW-1:0] LAST_EDGE = CW'(EDGE_COUNT - 1);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // oscillator synchronizers: index 0 primary, 1 secondary, 2 RC
  logic [NUM_SRC-1:0] osc_in, rise, fall;
  assign osc_in = {rc_osc_i, sec_osc_i, pri_osc_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    clksw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .async_i(osc_in[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  logic unused_falls;
  assign unused_falls = fall[0] ^ fall[2];

  // select rewrite and decode
  logic [1:0] sel_final;
  src_e       tgt_src;
  clksw_sel u_sel (
    .req_i   (sel_i),
    .osc_en_i(sec_osc_en_i),
    .final_o (sel_final),
    .tgt_o   (tgt_src)
  );

  // state
  logic [1:0] sel_q, sel_d;
  src_e       act_q, act_d;
  logic       pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic       srun_q, srun_d;
  logic       ost_q, ost_d;
  logic       tick;

  always_comb begin
    sel_d  = sel_q;
    act_d  = act_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    srun_d = srun_q;
    ost_d  = ost_q;
    if (ost_set_i) ost_d = 1'b1;
    if (sel_wr_i) begin
      sel_d = sel_final;
      if (sel_final != sel_q) begin
        pend_d = 1'b0;
        cnt_d  = '0;
        if (tgt_src == act_q) begin
          // request matches the running source: nothing to move
        end else if (tgt_src == SRC_SEC) begin
          pend_d = 1'b1;
          ost_d  = 1'b0;
        end else begin
          act_d  = tgt_src;
          srun_d = 1'b0;
        end
      end
    end else if (pend_q && fall[1]) begin
      if (cnt_q == LAST_EDGE) begin
        pend_d = 1'b0;
        cnt_d  = '0;
        act_d  = SRC_SEC;
        srun_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q  <= 2'b00;
      act_q  <= SRC_PRI;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      srun_q <= 1'b0;
      ost_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      srun_q <= srun_d;
      ost_q  <= ost_d;
    end
  end

  always_comb begin
    unique case (act_q)
      SRC_SEC: tick = rise[1];
      SRC_RC:  tick = rise[2];
      default: tick = rise[0];
    endcase
  end

  clksw_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .hold_i (pend_d),
    .tick_i (tick),
    .phase_o(phase_o)
  );

  assign sel_o        = sel_q;
  assign active_src_o = act_q;
  assign switching_o  = pend_q;
  assign sec_run_o    = srun_q;
  assign ost_o        = ost_q;
  assign pri_clk_en_o = (act_q == SRC_PRI) && !pend_q;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_wr_i,
  input logic [1:0] active_src_o,
  input logic [3:0] phase_o,
  input logic       switching_o,
  input logic       sec_run_o,
  input logic       ost_o,
  input logic       pri_clk_en_o
);
  assert_phase_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);

  assert_hold_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switching_o |-> phase_o == 4'b0001);

  assert_start_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(switching_o) |-> (!ost_o && !pri_clk_en_o));

  assert_done_from_pend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_run_o) |-> ($past(switching_o) && active_src_o == 2'b01));

  assert_run_means_sec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_run_o |-> active_src_o == 2'b01);

  assert_quiet_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_wr_i && !switching_o) |=> $stable(active_src_o));
endmodule

bind clksw_ctrl clksw_ctrl_chk chk_i (.*);

// File: tb/clksw_ctrl_tb_top.sv
`timescale 1ns/1ps
module clksw_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pri_osc_i = 1'b0, rc_osc_i = 1'b0, sec_osc_i = 1'b0;
  logic       sel_wr_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       sec_osc_en_i = 1'b1;
  logic       ost_set_i = 1'b0;
  logic [1:0] sel_o, active_src_o;
  logic [3:0] phase_o;
  logic       switching_o, sec_run_o, ost_o, pri_clk_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5  clk_i = ~clk_i;
  always #20 pri_osc_i = ~pri_osc_i;
  always #30 rc_osc_i  = ~rc_osc_i;
  initial begin #7; forever #40 sec_osc_i = ~sec_osc_i; end

  clksw_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] v, input logic en);
    @(negedge clk_i);
    sel_i = v; sec_osc_en_i = en; sel_wr_i = 1'b1;
    @(negedge clk_i);
    sel_wr_i = 1'b0;
  endtask

  task automatic pulse_ost();
    @(negedge clk_i); ost_set_i = 1'b1;
    @(negedge clk_i); ost_set_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sel", sel_o, 2'b00);
    chk("R1 src", active_src_o, 2'b00);
    chk("R1 phase", phase_o, 4'b0001);
    chk("R1 switching", switching_o, 0);
    chk("R1 sec_run", sec_run_o, 0);
    chk("R1 ost", ost_o, 0);
    chk("R1 pri_en", pri_clk_en_o, 1);
  endtask

  task automatic t_phase_rotation(input string tag);
    logic [3:0] prev;
    int steps_ok = 1;
    int moves = 0;
    @(negedge clk_i); prev = phase_o;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if ($countones(phase_o) != 1) steps_ok = 0;
      if (phase_o != prev) begin
        if (phase_o != {prev[2:0], prev[3]}) steps_ok = 0;
        moves++;
      end
      prev = phase_o;
    end
    chk({tag, " R11 rotation order"}, steps_ok, 1);
    chk({tag, " R11 advances"}, (moves >= 2), 1);
  endtask

  task automatic t_ost_same_write();
    pulse_ost();
    chk("R12 ost set", ost_o, 1);
    wr(2'b00, 1'b1);
    chk("R4 same write src", active_src_o, 2'b00);
    chk("R4 same write switching", switching_o, 0);
    chk("R4 same write ost", ost_o, 1);
  endtask

  task automatic t_rewrite();
    wr(2'b01, 1'b0);
    chk("R3 00+01 sel", sel_o, 2'b00);
    chk("R3 00+01 src", active_src_o, 2'b00);
    chk("R3 00+01 no switch", switching_o, 0);
    wr(2'b11, 1'b0);
    chk("R3 00+11 sel", sel_o, 2'b10);
    chk("R9 rc src", active_src_o, 2'b10);
    chk("R9 rc pri off", pri_clk_en_o, 0);
    wr(2'b11, 1'b0);
    chk("R3 10+11 sel", sel_o, 2'b10);
    wr(2'b01, 1'b0);
    chk("R3 10+01 sel", sel_o, 2'b00);
    chk("R9 pri src", active_src_o, 2'b00);
    chk("R9 pri on", pri_clk_en_o, 1);
  endtask

  task automatic wait_falls_then_settle(input int n);
    repeat (n) @(negedge sec_osc_i);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_switch_sec();
    pulse_ost();
    @(posedge sec_osc_i);
    wr(2'b01, 1'b1);
    chk("R5 switching", switching_o, 1);
    chk("R5 ost cleared", ost_o, 0);
    chk("R5 pri off", pri_clk_en_o, 0);
    chk("R2 sel 01", sel_o, 2'b01);
    wait_falls_then_settle(7);
    chk("R7 not done after 7", sec_run_o, 0);
    chk("R6 held first phase", phase_o, 4'b0001);
    chk("R7 still switching", switching_o, 1);
    wait_falls_then_settle(1);
    chk("R8 sec_run", sec_run_o, 1);
    chk("R8 src sec", active_src_o, 2'b01);
    chk("R8 switch done", switching_o, 0);
  endtask

  task automatic t_leave_sec();
    wr(2'b10, 1'b1);
    chk("R9 leave sec src", active_src_o, 2'b10);
    chk("R9 leave sec run", sec_run_o, 0);
    wr(2'b00, 1'b1);
    chk("R9 back pri", active_src_o, 2'b00);
  endtask

  task automatic t_abort();
    @(posedge sec_osc_i);
    wr(2'b01, 1'b1);
    repeat (3) @(negedge sec_osc_i);
    wr(2'b00, 1'b1);
    chk("R10 abort switching", switching_o, 0);
    chk("R10 abort src", active_src_o, 2'b00);
    chk("R10 abort pri on", pri_clk_en_o, 1);
    wait_falls_then_settle(10);
    chk("R10 aborted never done", sec_run_o, 0);
    @(posedge sec_osc_i);
    wr(2'b01, 1'b1);
    repeat (3) @(negedge sec_osc_i);
    @(posedge sec_osc_i);
    wr(2'b11, 1'b1);
    chk("R10 restart switching", switching_o, 1);
    wait_falls_then_settle(7);
    chk("R10 fresh count not done", sec_run_o, 0);
    wait_falls_then_settle(1);
    chk("R10 fresh count done", sec_run_o, 1);
    chk("R2 11 selects sec", active_src_o, 2'b01);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_phase_rotation("pri");
    t_ost_same_write();
    t_rewrite();
    t_switch_sec();
    t_phase_rotation("sec");
    t_leave_sec();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule